// File: doc/BRIEF.md
# Multi-Channel Timer Tick Generator

This block derives five clock-enable strobes, one per timer channel, from a single reference clock whose nominal rate is 24 MHz. Two 8-bit prescale values are shared unevenly between the channels. The first channel group, channels 0 and 1, uses one of them. The second group, channels 2 to 4, uses the other. Behind its prescaler, each channel applies its own power-of-two divider, chosen by a 4-bit select field. A downstream counter bank advances one step on each strobe. The counters are not part of this block.

Both configuration words are presented as levels. The block holds a registered copy of each word. When either word differs from its copy, every prescaler and every divider restarts from the new values in the same cycle. The first strobe after a change therefore arrives one full new period later, and no interval left over from the old ratio remains. Select values above 4 are clamped to divide-by-16.

Top module: `tick_gen_bank`

## Requirements
- R1: While rst_ni is low, tick_o is 0. After reset the internal configuration is prescaler bytes 0x01 and all selects 0. With the inputs held at those values, every channel ticks in the first cycle after reset release and then every 2 cycles.
- R2: Channels 0 and 1 use prescale value P = pre_cfg_i[7:0].
- R3: Channels 2, 3 and 4 use prescale value P = pre_cfg_i[15:8].
- R4: Channel x takes its select S from div_cfg_i[4x+3:4x]. In steady state the channel ticks every (P+1)*2^S cycles.
- R5: A select value from 5 to 15 behaves as 4, giving a period of (P+1)*16.
- R6: When a channel's period is greater than 1, its tick is high for exactly one cycle per period.
- R7: Suppose new configuration values are applied just after a clock edge. Each channel's first tick then appears exactly one new period later, at the sample point after the period's final clock edge.
- R8: A change to any field of either word restarts all five channels, including channels whose own fields did not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pre_cfg_i | input | 16 | Two prescale bytes: [7:0] for channels 0-1, [15:8] for channels 2-4 |
| div_cfg_i | input | 20 | Five 4-bit divider selects, channel x at [4x+3:4x] |
| tick_o | output | 5 | One clock-enable strobe per channel |

## Verification
The period of every channel is measured under several configuration pairs. These include unequal prescale bytes, so that a swapped mapping of channel groups to prescale bytes gives the wrong period on the affected channels. Select patterns that rise or fall across the channels expose a misplaced field or a wrong power of two. Selects of 5, 9 and 15 separate the clamp from plain wrap-around. Prescale values of 0 and 255 test the counter at both ends. The delay to the first tick after a change is measured, and so is the delay after a change that touches only one other channel's field. These delays separate a real restart from a counter that keeps its old phase.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned PRE_W_DEF     = 8;
  localparam int unsigned SEL_W_DEF     = 4;
  localparam int unsigned NUM_CH_DEF    = 5;
  localparam int unsigned NUM_PRE_DEF   = 2;
  localparam int unsigned GRP_SPLIT_DEF = 2;
  localparam int unsigned MAX_SHIFT_DEF = 4;

  // divider reload for a select, clamped at max_shift
  function automatic int unsigned div_reload(input int unsigned sel, input int unsigned max_shift);
    int unsigned eff;
    eff = (sel > max_shift) ? max_shift : sel;
    return (32'd1 << eff) - 32'd1;
  endfunction
endpackage

// File: rtl/tick_cfg_track.sv
module tick_cfg_track #(
  parameter int unsigned PRE_BITS = 16,
  parameter int unsigned DIV_BITS = 20,
  parameter logic [PRE_BITS-1:0] PRE_RST = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PRE_BITS-1:0] pre_i,
  input  logic [DIV_BITS-1:0] div_i,
  output logic [PRE_BITS-1:0] pre_q_o,
  output logic [DIV_BITS-1:0] div_q_o,
  output logic                restart_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q_o <= PRE_RST;
      div_q_o <= '0;
    end else begin
      pre_q_o <= pre_i;
      div_q_o <= div_i;
    end
  end

  assign restart_o = (pre_i != pre_q_o) || (div_i != div_q_o);

  AST_RESTART_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o && $stable(pre_i) && $stable(div_i) |=> !restart_o); // R8
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned PRE_W = 8,
  parameter logic [PRE_W-1:0] RST_VAL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] load_val_i,
  input  logic [PRE_W-1:0] reload_i,
  output logic             stb_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= RST_VAL;
    else if (restart_i)      cnt_q <= load_val_i;
    else if (cnt_q == '0)    cnt_q <= reload_i;
    else                     cnt_q <= cnt_q - 1'b1;
  end

  assign stb_o = (cnt_q == '0) && !restart_i;

  AST_PRE_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1); // R4
  AST_PRE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> cnt_q == $past(reload_i)); // R4
  AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |-> cnt_q <= reload_i); // R7
endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import tick_pkg::*;
#(
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned MAX_SHIFT = 4,
  localparam int unsigned CNT_W    = (MAX_SHIFT > 0) ? MAX_SHIFT : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             stb_i,
  input  logic [SEL_W-1:0] sel_new_i,
  input  logic [SEL_W-1:0] sel_cur_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rl_new, rl_cur;

  assign rl_new = CNT_W'(div_reload(int'(sel_new_i), MAX_SHIFT));
  assign rl_cur = CNT_W'(div_reload(int'(sel_cur_i), MAX_SHIFT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (restart_i)   cnt_q <= rl_new;
    else if (stb_i) begin
      if (cnt_q == '0)    cnt_q <= rl_cur;
      else                cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick_o = stb_i && (cnt_q == '0);

  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i && !restart_i |=> $stable(cnt_q)); // R4
  AST_DIV_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == $past(rl_cur)); // R5
endmodule

// File: rtl/tick_gen_bank.sv
module tick_gen_bank
  import tick_pkg::*;
#(
  parameter int unsigned PRE_W     = PRE_W_DEF,
  parameter int unsigned SEL_W     = SEL_W_DEF,
  parameter int unsigned NUM_CH    = NUM_CH_DEF,
  parameter int unsigned NUM_PRE   = NUM_PRE_DEF,
  parameter int unsigned GRP_SPLIT = GRP_SPLIT_DEF,
  parameter int unsigned MAX_SHIFT = MAX_SHIFT_DEF,
  localparam int unsigned PRE_BITS = NUM_PRE * PRE_W,
  localparam int unsigned DIV_BITS = NUM_CH * SEL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PRE_BITS-1:0] pre_cfg_i,
  input  logic [DIV_BITS-1:0] div_cfg_i,
  output logic [NUM_CH-1:0]   tick_o
);
  localparam logic [PRE_W-1:0]    PRE_ONE = PRE_W'(1);
  localparam logic [PRE_BITS-1:0] PRE_RST = {NUM_PRE{PRE_ONE}};

  logic [PRE_BITS-1:0] pre_q;
  logic [DIV_BITS-1:0] div_q;
  logic                restart;
  logic [NUM_PRE-1:0]  pre_stb;

  tick_cfg_track #(
    .PRE_BITS(PRE_BITS),
    .DIV_BITS(DIV_BITS),
    .PRE_RST (PRE_RST)
  ) i_cfg_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pre_i    (pre_cfg_i),
    .div_i    (div_cfg_i),
    .pre_q_o  (pre_q),
    .div_q_o  (div_q),
    .restart_o(restart)
  );

  for (genvar g = 0; g < NUM_PRE; g++) begin : g_pre
    tick_prescaler #(
      .PRE_W  (PRE_W),
      .RST_VAL(PRE_ONE)
    ) i_pre (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .load_val_i(pre_cfg_i[g*PRE_W +: PRE_W]),
      .reload_i  (pre_q[g*PRE_W +: PRE_W]),
      .stb_o     (pre_stb[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // first GRP_SPLIT channels on prescaler 0, rest on the last one
    localparam int unsigned GRP = (c < GRP_SPLIT) ? 0 : NUM_PRE - 1;

    tick_divider #(
      .SEL_W    (SEL_W),
      .MAX_SHIFT(MAX_SHIFT)
    ) i_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .restart_i(restart),
      .stb_i    (pre_stb[GRP]),
      .sel_new_i(div_cfg_i[c*SEL_W +: SEL_W]),
      .sel_cur_i(div_q[c*SEL_W +: SEL_W]),
      .tick_o   (tick_o[c])
    );

    AST_TICK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o[c] |-> pre_stb[GRP]); // R3
  end

  AST_NO_TICK_ON_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |-> tick_o == '0); // R7
endmodule

// File: tb/test_tick_gen_bank.sv
module test_tick_gen_bank;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 20000;
  localparam int WDOG       = 190000;
  localparam int NVEC       = 6;
  // {pre_cfg, div_cfg}
  localparam logic [35:0] VEC [NVEC] = '{
    {16'h0302, 20'h43210},
    {16'h0000, 20'h00000},
    {16'h0A05, 20'h01234},
    {16'h07FF, 20'hF5921},
    {16'h1300, 20'h12340},
    {16'h0101, 20'h00000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pre_cfg = 16'h0101;
  logic [19:0] div_cfg = 20'h0;
  logic [4:0]  tick;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_gen_bank i_tick_gen_bank (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .pre_cfg_i(pre_cfg),
    .div_cfg_i(div_cfg),
    .tick_o   (tick)
  );

  initial begin
    wait (cyc >= WDOG);
    $display("FAIL watchdog: req=all act=%0d exp<%0d", cyc, WDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // R4/R5 formula: (P+1) * 2^min(S,4), P by channel group (R2, R3)
  function automatic int exp_period(input logic [15:0] p, input logic [19:0] d, input int ch);
    int pv, s;
    pv = (ch < 2) ? int'(p[7:0]) : int'(p[15:8]);
    s  = int'(d[ch*4 +: 4]);
    if (s > 4) s = 4;
    return (pv + 1) * (1 << s);
  endfunction

  task automatic wait_tick(input int ch);
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      if (tick[ch]) return;
    end
  endtask

  task automatic measure(input int ch, input int exp, input string req);
    int c;
    wait_tick(ch);
    c = 0;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      c++;
      if (tick[ch]) break;
    end
    check(c == exp, req, c, exp);
  endtask

  // apply at a negedge, count sample points to first tick on ch
  task automatic first_tick(input logic [15:0] p, input logic [19:0] d, input int ch,
                            input int exp, input string req);
    int c;
    pre_cfg = p;
    div_cfg = d;
    c = 0;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      c++;
      if (tick[ch]) break;
    end
    check(c == exp, req, c, exp);
  endtask

  initial begin
    int c;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(tick == 5'd0, "R1 tick low in reset", int'(tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tick == 5'h1F, "R1 first tick after reset", int'(tick), 31);
    @(negedge clk);
    check(tick == 5'h00, "R1 gap after first tick", int'(tick), 0);
    for (int ch = 0; ch < 5; ch++) measure(ch, 2, "R1 reset period");

    // vector walk: R7 first-tick latency, R2/R3/R4/R5 periods
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] p;
      logic [19:0] d;
      p = VEC[v][35:20];
      d = VEC[v][19:0];
      @(negedge clk);
      first_tick(p, d, 0, exp_period(p, d, 0), "R7 first tick after change");
      for (int ch = 0; ch < 5; ch++)
        measure(ch, exp_period(p, d, ch), ch < 2 ? "R2 R4 R5 period" : "R3 R4 R5 period");
    end

    // R6: single-cycle strobe on a slow channel
    pre_cfg = 16'h0302;
    div_cfg = 20'h00300;
    wait_tick(2);
    @(negedge clk);
    check(tick[2] == 1'b0, "R6 strobe width", int'(tick[2]), 0);
    measure(2, 32, "R4 sel3 period");

    // R5: select 15 and 5 clamp
    pre_cfg = 16'h0100;
    div_cfg = 20'h00F05;
    measure(0, 16, "R5 sel5 clamp");
    measure(2, 32, "R5 sel15 clamp");

    // R8: change only channel 4 field, channel 0 restarts
    pre_cfg = 16'h0105;
    div_cfg = 20'h00000;
    measure(0, 6, "R2 period before R8");
    wait_tick(0);
    repeat (2) @(negedge clk);
    first_tick(16'h0105, 20'h30000, 0, 6, "R8 restart of untouched channel");
    measure(4, 16, "R8 ch4 new ratio");

    // R7: channel 3 latency with a divider
    @(negedge clk);
    first_tick(16'h0201, 20'h02000, 3, 12, "R7 latency with divider");

    c = checks;
    $display("TB_RESULT checks=%0d failures=%0d", c, fails);
    $finish;
  end
endmodule